// File: doc/BRIEF.md
# Video Frame Timing Generator

This block plays the camera's role toward a frame grabber. It produces the frame-valid, line-valid and data-valid qualifiers, together with a pixel-request strobe and column and row coordinates. An external pixel path presents one pixel for every request. The timing is chosen to suit as many grabbers as possible: a programmable gap from frame-valid rising to the first line-valid, a programmable gap from the last line-valid falling to frame-valid falling, and no line-valid outside a frame. Every line has the same length and every frame has the same number of lines.

The frame geometry comes from inputs held by the surrounding logic: pixels per line, lines per frame, lead gap, trail gap, line blanking and frame blanking. A pacing divisor selects the data-valid mode. With a divisor of zero, data-valid stays high permanently and a pixel is taken on every clock of a line. With a non-zero divisor, data-valid is pulsed for clocks slower than one pixel per clock. All of these values are captured only when a frame starts. While `enable` is high, frames follow one another. When `enable` drops, the frame in progress and its blanking finish, and then the generator waits.

Top module: `camTimingGen`

## Requirements
- R1: While reset is applied and afterwards until the first frame, frameValid, lineValid and pixReq are 0, dataValid is 1, and pixCol and pixRow are 0.
- R2: The first lineValid of a frame rises exactly max(leadGap,1) clocks after frameValid rises, so frameValid and lineValid never rise together.
- R3: frameValid falls exactly max(trailGap,1) clocks after lineValid falls on the last line of a frame.
- R4: Every frame has max(frameLines,1) lines. Each line's lineValid lasts (N-1)*(D+1)+1 clocks, where N = max(lineLen,1) and D = paceDiv. Consecutive lines in a frame are separated by max(lineGap,1) clocks of lineValid low.
- R5: While enable stays 1, frameValid is low for exactly max(frameGap,1) clocks between two frames.
- R6: lineValid is never 1 while frameValid is 0.
- R7: With paceDiv = 0, dataValid is constantly 1. With paceDiv = D > 0, dataValid is 1 on the first clock of a line and on every (D+1)th clock after it within the line, and it is 0 at all other times.
- R8: pixReq is 1 exactly when lineValid and dataValid are both 1. On successive requests within a line, pixCol takes the values 0,1,...,N-1. pixRow equals the line index within the frame, starting at 0.
- R9: All geometry and pacing inputs are sampled only when a frame starts. Changing them during a frame does not alter that frame, and the next frame uses the new values.
- R10: When enable goes to 0, the current frame completes in full and no further frame starts until enable is 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; every output changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run frames continuously while high |
| lineLen | input | COL_W | Pixels per line (0 treated as 1) |
| frameLines | input | ROW_W | Lines per frame (0 treated as 1) |
| leadGap | input | GAP_W | Clocks from frameValid rise to first lineValid (0 treated as 1) |
| trailGap | input | GAP_W | Clocks from last lineValid fall to frameValid fall (0 treated as 1) |
| lineGap | input | GAP_W | Blanking clocks between lines (0 treated as 1) |
| frameGap | input | GAP_W | Clocks of frameValid low between frames (0 treated as 1) |
| paceDiv | input | PACE_W | Data-valid pacing divisor; 0 keeps dataValid high |
| frameValid | output | 1 | Frame qualifier |
| lineValid | output | 1 | Line qualifier |
| dataValid | output | 1 | Data qualifier |
| pixReq | output | 1 | Present a pixel this clock |
| pixCol | output | COL_W | Column of the requested pixel |
| pixRow | output | ROW_W | Row of the current line |

## Verification
A wrong state register shows up at once, because every qualifier is decoded straight from it. A state that jumps early into the line phase makes frameValid and lineValid rise together on the very clock of the jump. A state stuck in blanking appears as a gap that has the wrong length. A gap counter that is off by one shows up as a lead, trail or blanking run that is one clock too long or too short, and this is visible at the first edge of that run. A faulty column or pace counter changes the line-valid width and the pixCol sequence within the first line. A faulty row counter or captured-configuration register shows up as the wrong line count or row number by the end of the first frame.

// File: rtl/camtg_pkg.sv
package camtg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_ACTIVE,
    ST_LBLANK,
    ST_TRAIL,
    ST_FBLANK
  } tgState_e;

  typedef enum logic [1:0] {
    SEL_LGAP,
    SEL_TRAIL,
    SEL_FGAP
  } cntSel_e;

  typedef struct packed {
    logic    startFrame;
    logic    loadCnt;
    cntSel_e sel;
    logic    inLine;
    logic    lineEnd;
    logic    rowInc;
  } ctlStb_t;

endpackage

// File: rtl/camTimingDp.sv
module camTimingDp
  import camtg_pkg::*;
#(
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12,
  parameter int GAP_W  = 8,
  parameter int PACE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStb_t           stb,
  input  logic [COL_W-1:0]  lineLenIn,
  input  logic [ROW_W-1:0]  frameLinesIn,
  input  logic [GAP_W-1:0]  leadIn,
  input  logic [GAP_W-1:0]  trailIn,
  input  logic [GAP_W-1:0]  lineGapIn,
  input  logic [GAP_W-1:0]  frameGapIn,
  input  logic [PACE_W-1:0] paceDivIn,
  output logic              cntZero,
  output logic              pixTick,
  output logic              lastPix,
  output logic              lastRow,
  output logic              paceOn,
  output logic [COL_W-1:0]  col,
  output logic [ROW_W-1:0]  row
);

  localparam logic [COL_W-1:0] COL_ONE = COL_W'(1);
  localparam logic [ROW_W-1:0] ROW_ONE = ROW_W'(1);
  localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

  logic [COL_W-1:0]  lineLenR;
  logic [ROW_W-1:0]  linesR;
  logic [GAP_W-1:0]  trailR, lineGapR, frameGapR;
  logic [PACE_W-1:0] paceR, pace;
  logic [GAP_W-1:0]  cnt;
  logic [GAP_W-1:0]  leadEff;

  // zero in any count field means one
  assign leadEff = (leadIn == '0) ? GAP_ONE : leadIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineLenR  <= COL_ONE;
      linesR    <= ROW_ONE;
      trailR    <= GAP_ONE;
      lineGapR  <= GAP_ONE;
      frameGapR <= GAP_ONE;
      paceR     <= '0;
    end else if (stb.startFrame) begin
      lineLenR  <= (lineLenIn == '0)    ? COL_ONE : lineLenIn;
      linesR    <= (frameLinesIn == '0) ? ROW_ONE : frameLinesIn;
      trailR    <= (trailIn == '0)      ? GAP_ONE : trailIn;
      lineGapR  <= (lineGapIn == '0)    ? GAP_ONE : lineGapIn;
      frameGapR <= (frameGapIn == '0)   ? GAP_ONE : frameGapIn;
      paceR     <= paceDivIn;
    end
  end

  // shared gap counter: loaded with length-1, counts down to zero
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.startFrame) begin
      cnt <= leadEff - GAP_ONE;
    end else if (stb.loadCnt) begin
      case (stb.sel)
        SEL_LGAP:  cnt <= lineGapR - GAP_ONE;
        SEL_TRAIL: cnt <= trailR - GAP_ONE;
        default:   cnt <= frameGapR - GAP_ONE;
      endcase
    end else if (cnt != '0) begin
      cnt <= cnt - GAP_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !stb.inLine) begin
      pace <= '0;
    end else if (pace == paceR) begin
      pace <= '0;
    end else begin
      pace <= pace + PACE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.lineEnd) begin
      col <= '0;
    end else if (stb.inLine && pixTick) begin
      col <= col + COL_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.startFrame) begin
      row <= '0;
    end else if (stb.rowInc) begin
      row <= row + ROW_ONE;
    end
  end

  assign cntZero = (cnt == '0);
  assign pixTick = (pace == '0);
  assign lastPix = (col == lineLenR - COL_ONE);
  assign lastRow = (row == linesR - ROW_ONE);
  assign paceOn  = (paceR != '0);

endmodule

// File: rtl/camTimingCtl.sv
module camTimingCtl
  import camtg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    enable,
  input  logic    cntZero,
  input  logic    pixTick,
  input  logic    lastPix,
  input  logic    lastRow,
  output ctlStb_t stb,
  output logic    frameValid,
  output logic    lineValid
);

  tgState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '{startFrame: 1'b0, loadCnt: 1'b0, sel: SEL_LGAP,
                  inLine: 1'b0, lineEnd: 1'b0, rowInc: 1'b0};
    case (state)
      ST_IDLE: begin
        if (enable) begin
          stb.startFrame = 1'b1;
          nextState      = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (cntZero) nextState = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        stb.inLine = 1'b1;
        if (pixTick && lastPix) begin
          stb.lineEnd = 1'b1;
          stb.loadCnt = 1'b1;
          if (lastRow) begin
            stb.sel   = SEL_TRAIL;
            nextState = ST_TRAIL;
          end else begin
            stb.sel    = SEL_LGAP;
            stb.rowInc = 1'b1;
            nextState  = ST_LBLANK;
          end
        end
      end
      ST_LBLANK: begin
        if (cntZero) nextState = ST_ACTIVE;
      end
      ST_TRAIL: begin
        if (cntZero) begin
          stb.loadCnt = 1'b1;
          stb.sel     = SEL_FGAP;
          nextState   = ST_FBLANK;
        end
      end
      ST_FBLANK: begin
        if (cntZero) begin
          if (enable) begin
            stb.startFrame = 1'b1;
            nextState      = ST_LEAD;
          end else begin
            nextState = ST_IDLE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign frameValid = (state == ST_LEAD) || (state == ST_ACTIVE) ||
                      (state == ST_LBLANK) || (state == ST_TRAIL);
  assign lineValid  = (state == ST_ACTIVE);

endmodule

// File: rtl/camTimingGen.sv
module camTimingGen
  import camtg_pkg::*;
#(
  parameter int COL_W  = 12,
  parameter int ROW_W  = 12,
  parameter int GAP_W  = 8,
  parameter int PACE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [COL_W-1:0]  lineLen,
  input  logic [ROW_W-1:0]  frameLines,
  input  logic [GAP_W-1:0]  leadGap,
  input  logic [GAP_W-1:0]  trailGap,
  input  logic [GAP_W-1:0]  lineGap,
  input  logic [GAP_W-1:0]  frameGap,
  input  logic [PACE_W-1:0] paceDiv,
  output logic              frameValid,
  output logic              lineValid,
  output logic              dataValid,
  output logic              pixReq,
  output logic [COL_W-1:0]  pixCol,
  output logic [ROW_W-1:0]  pixRow
);

  ctlStb_t stb;
  logic    cntZero, pixTick, lastPix, lastRow, paceOn;

  camTimingCtl uCtl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .cntZero    (cntZero),
    .pixTick    (pixTick),
    .lastPix    (lastPix),
    .lastRow    (lastRow),
    .stb        (stb),
    .frameValid (frameValid),
    .lineValid  (lineValid)
  );

  camTimingDp #(
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .GAP_W  (GAP_W),
    .PACE_W (PACE_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .lineLenIn    (lineLen),
    .frameLinesIn (frameLines),
    .leadIn       (leadGap),
    .trailIn      (trailGap),
    .lineGapIn    (lineGap),
    .frameGapIn   (frameGap),
    .paceDivIn    (paceDiv),
    .cntZero      (cntZero),
    .pixTick      (pixTick),
    .lastPix      (lastPix),
    .lastRow      (lastRow),
    .paceOn       (paceOn),
    .col          (pixCol),
    .row          (pixRow)
  );

  assign dataValid = paceOn ? (lineValid && pixTick) : 1'b1;
  assign pixReq    = lineValid && dataValid;

endmodule

// File: rtl/camTimingGen_chk.sv
module camTimingGen_chk #(
  parameter int COL_W = 12,
  parameter int ROW_W = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameValid,
  input logic             lineValid,
  input logic             pixReq,
  input logic [COL_W-1:0] pixCol,
  input logic [ROW_W-1:0] pixRow
);

  AST_LINE_IN_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    lineValid |-> frameValid);  // R6

  AST_LEAD_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameValid) |-> !lineValid);  // R2

  AST_TRAIL_GAP: assert property (@(posedge clk) disable iff (!rstN)
    $fell(frameValid) |-> !$past(lineValid));  // R3

  AST_COL_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineValid) |-> (pixCol == '0));  // R8

  AST_ROW_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameValid) |-> (pixRow == '0));  // R8

  AST_COL_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && $past(lineValid) && $past(pixReq))
      |-> (pixCol == $past(pixCol) + COL_W'(1)));  // R8

  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (lineValid && $past(lineValid)) |-> $stable(pixRow));  // R4

endmodule

bind camTimingGen camTimingGen_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .lineValid  (lineValid),
  .pixReq     (pixReq),
  .pixCol     (pixCol),
  .pixRow     (pixRow)
);

// File: tb/camTimingGen_test.sv
module camTimingGen_test;

  localparam int CLK_PERIOD = 10;
  localparam int COL_W  = 12;
  localparam int ROW_W  = 12;
  localparam int GAP_W  = 8;
  localparam int PACE_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [COL_W-1:0]  lineLen = '0;
  logic [ROW_W-1:0]  frameLines = '0;
  logic [GAP_W-1:0]  leadGap = '0, trailGap = '0, lineGap = '0, frameGap = '0;
  logic [PACE_W-1:0] paceDiv = '0;
  logic frameValid, lineValid, dataValid, pixReq;
  logic [COL_W-1:0] pixCol;
  logic [ROW_W-1:0] pixRow;

  int vecCnt = 0;
  int errCnt = 0;
  bit doneFlag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  camTimingGen #(.COL_W(COL_W), .ROW_W(ROW_W), .GAP_W(GAP_W), .PACE_W(PACE_W)) uut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .lineLen(lineLen), .frameLines(frameLines),
    .leadGap(leadGap), .trailGap(trailGap), .lineGap(lineGap), .frameGap(frameGap),
    .paceDiv(paceDiv),
    .frameValid(frameValid), .lineValid(lineValid), .dataValid(dataValid),
    .pixReq(pixReq), .pixCol(pixCol), .pixRow(pixRow)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic setCfg(input int len, input int lines, input int lead, input int trail,
                        input int lg, input int fg, input int div);
    lineLen    = COL_W'(len);
    frameLines = ROW_W'(lines);
    leadGap    = GAP_W'(lead);
    trailGap   = GAP_W'(trail);
    lineGap    = GAP_W'(lg);
    frameGap   = GAP_W'(fg);
    paceDiv    = PACE_W'(div);
  endtask

  task automatic applyReset();
    enable = 1'b0;
    rstN   = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // Walks one complete frame at negedges; expected values are effective (clamped) ones.
  task automatic checkFrame(input int eLead, input int eLen, input int eLines,
                            input int eLgap, input int eTrail, input int eDiv);
    int c = 0;
    int lvBad = 0;
    int dvBad = 0;
    int colBad = 0;
    int rowBad = 0;
    while (!frameValid) begin
      if (lineValid) lvBad++;
      @(negedge clk);
    end
    while (frameValid && !lineValid) begin
      if (eDiv != 0 && dataValid) dvBad++;
      c++;
      @(negedge clk);
    end
    check(c == eLead, "R2", "lead clocks", c, eLead);
    for (int ln = 0; ln < eLines; ln++) begin
      int run = 0;
      int px = 0;
      int gap = 0;
      while (lineValid) begin
        if (!frameValid) lvBad++;
        if (eDiv == 0) begin
          if (!dataValid) dvBad++;
        end else if (dataValid != ((run % (eDiv + 1)) == 0)) begin
          dvBad++;
        end
        if (pixReq != (lineValid && dataValid)) dvBad++;
        if (pixReq) begin
          if (int'(pixCol) != px) colBad++;
          px++;
        end
        if (int'(pixRow) != ln) rowBad++;
        run++;
        @(negedge clk);
      end
      check(run == (eLen - 1) * (eDiv + 1) + 1, "R4", "line width", run,
            (eLen - 1) * (eDiv + 1) + 1);
      check(px == eLen, "R8", "requests per line", px, eLen);
      while (frameValid && !lineValid) begin
        if (eDiv != 0 && dataValid) dvBad++;
        gap++;
        @(negedge clk);
      end
      if (ln < eLines - 1) begin
        check(gap == eLgap && lineValid, "R4", "line blanking", gap, eLgap);
      end else begin
        check(gap == eTrail && !frameValid, "R3", "trail clocks", gap, eTrail);
      end
    end
    check(lvBad == 0, "R6", "lineValid outside frame", lvBad, 0);
    check(dvBad == 0, "R7", "dataValid pattern errors", dvBad, 0);
    check(colBad == 0 && rowBad == 0, "R8", "coordinate errors", colBad + rowBad, 0);
  endtask

  task automatic measureGap(input int eGap);
    int c = 0;
    while (!frameValid && c < 1000) begin
      c++;
      @(negedge clk);
    end
    check(c == eGap, "R5", "frame blanking", c, eGap);
  endtask

  task automatic testReset();
    rstN = 1'b0;
    setCfg(8, 3, 4, 3, 2, 5, 0);
    repeat (2) @(negedge clk);
    check(!frameValid && !lineValid && !pixReq, "R1", "qualifiers in reset",
          {frameValid, lineValid, pixReq}, 0);
    check(dataValid, "R1", "dataValid in reset", dataValid, 1);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(!frameValid && !lineValid && dataValid && pixCol == 0 && pixRow == 0,
          "R1", "idle outputs", {frameValid, lineValid, dataValid}, 1);
  endtask

  task automatic testBasic();
    applyReset();
    setCfg(8, 3, 4, 3, 2, 5, 0);
    enable = 1'b1;
    checkFrame(4, 8, 3, 2, 3, 0);
    measureGap(5);
    checkFrame(4, 8, 3, 2, 3, 0);
    enable = 1'b0;
  endtask

  task automatic testMinimum();
    applyReset();
    setCfg(0, 2, 0, 0, 0, 0, 0);
    enable = 1'b1;
    checkFrame(1, 1, 2, 1, 1, 0);
    measureGap(1);
    checkFrame(1, 1, 2, 1, 1, 0);
    enable = 1'b0;
  endtask

  task automatic testPace();
    applyReset();
    setCfg(4, 2, 3, 2, 3, 2, 2);
    enable = 1'b1;
    checkFrame(3, 4, 2, 3, 2, 2);
    measureGap(2);
    enable = 1'b0;
  endtask

  task automatic testReload();
    applyReset();
    setCfg(5, 2, 2, 2, 1, 3, 0);
    enable = 1'b1;
    fork
      checkFrame(2, 5, 2, 1, 2, 0);
      begin
        repeat (3) @(negedge clk);
        setCfg(3, 3, 6, 4, 2, 7, 0);  // R9: new values mid-frame
      end
    join
    measureGap(3);
    checkFrame(6, 3, 3, 2, 4, 0);
    enable = 1'b0;
  endtask

  task automatic testStop();
    int high = 0;
    applyReset();
    setCfg(6, 3, 2, 2, 2, 2, 0);
    enable = 1'b1;
    fork
      checkFrame(2, 6, 3, 2, 2, 0);
      begin
        repeat (4) @(negedge clk);
        enable = 1'b0;  // R10: drop mid-frame
      end
    join
    for (int i = 0; i < 80; i++) begin
      if (frameValid) high++;
      @(negedge clk);
    end
    check(high == 0, "R10", "frames after disable", high, 0);
  endtask

  initial begin
    testReset();
    testBasic();
    testMinimum();
    testPace();
    testReload();
    testStop();
    doneFlag = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!doneFlag && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!doneFlag) begin
      vecCnt++;
      errCnt++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule